// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block is the status-register slice of a serial NOR flash slave on an SPI mode 0 bus. It decodes the commands that read and write an 8-bit status byte and set the write-enable latch. It also checks page-program, sector-erase and bulk-erase commands against the protection settings. An accepted program or erase command is handed to the array as a one-cycle request that carries a kind and an address.

All SPI lines are sampled in the `clk_i` domain, and the serial clock must run well below `clk_i`. A command takes effect on the rising edge of chip select. Its bit count must match the command's framing, or the command is dropped. The array's busy time is modelled by a counter of `BUSY_CYCLES` clock cycles. The protection bits are treated as non-volatile: `soft_rst_i` clears only the volatile state, and only `rst_ni` clears the protection bits.

Top module: `sfsr_unit`

## Requirements
- R1: The status byte is {SRWD, 0, 0, BP[2:0], WEL, WIP}, from bit 7 down to bit 0. Bits 6 and 5 always read 0, and the byte is 0x00 after `rst_ni`.
- R2: Opcode 0x05 returns the status byte MSB first. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. The byte repeats for as long as CS stays low, and each repeat holds the value the register has when that byte starts.
- R3: `miso_oe_o` is 0 while CS is high and while the 8 opcode bits are shifted in. It is 1 while status bytes are being returned.
- R4: Opcode 0x06, framed as exactly 8 bits, sets WEL. Any other bit count leaves WEL unchanged.
- R5: Opcode 0x01, framed as exactly 16 bits and sent while WEL=1, loads SRWD from data bit 7 and BP from data bits 4:2, then starts a busy cycle.
- R6: An accepted status write, program or erase sets WIP for `BUSY_CYCLES` clock cycles, after which WIP and WEL both read 0. While WIP=1, every command except 0x05 is ignored.
- R7: While WEL=0, status write, program and erase commands are ignored.
- R8: Page program (0x02 with a 24-bit address and at least one data byte, whole bytes) and sector erase (0xD8 with a 24-bit address, exactly 32 bits) are rejected if the address falls in the protected region. For BP=n, n=0 protects nothing, n=1..6 protects the top 1/2^(8-n) of the array, and n=7 protects the whole array.
- R9: Bulk erase (0xC7, exactly 8 bits) is accepted only when BP=0.
- R10: When SRWD=1 and `wp_ni` is low, status write is rejected and SRWD and BP stay unchanged. When `wp_ni` is high, status write works normally.
- R11: Each accepted program or erase raises `op_go_o` for one cycle, with `op_kind_o` set to 1 for program, 2 for sector erase or 3 for bulk erase, and `op_addr_o` set to the received address.
- R12: `soft_rst_i` clears WEL, WIP and any frame in progress but keeps SRWD and BP. `rst_ni` clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all state |
| soft_rst_i | input | 1 | Synchronous soft reset of the volatile state |
| sck_i | input | 1 | Serial clock, mode 0 |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Write-protect pin, active low |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for miso_o |
| op_go_o | output | 1 | One-cycle array operation request |
| op_kind_o | output | 2 | Operation kind: 1 program, 2 sector erase, 3 bulk erase |
| op_addr_o | output | ADDR_W | Operation address |

## Verification
A wrong WEL or WIP value shows up at the ports in two ways. It changes bits 1:0 of the very next status read. It also changes whether the next program or erase raises `op_go_o`, one cycle after chip select rises. A faulty protection decode appears as a request at a boundary address that should not have one, or no request where one is due. The bench therefore probes both sides of each region edge. A lost or corrupted BP or SRWD bit is visible in the next status byte, and it survives a soft reset, so it stays visible for as long as the fault persists.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam int WIRE_ADDR_W = 24;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_PP   = 2'd1,
    KIND_SE   = 2'd2,
    KIND_BE   = 2'd3
  } op_kind_e;
endpackage

// File: rtl/sfsr_spi_front.sv
module sfsr_spi_front
  import sfsr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [7:0]        status_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              frame_end_o,
  output logic [7:0]        opcode_o,
  output logic [7:0]        data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  bits_o
);
  logic sck_q, cs_q;
  logic [31:0] sh_q;
  logic [31:0] sh_nxt;
  logic [CNT_W-1:0] bits_q;
  logic opc_vld_q;
  logic [7:0] opcode_q, data_q;
  logic [WIRE_ADDR_W-1:0] addr_q;
  logic [7:0] out_q;
  logic miso_q, oe_q;

  logic sck_rise, sck_fall, cs_fall, rd_act;
  assign sck_rise = sck_i & ~sck_q;
  assign sck_fall = ~sck_i & sck_q;
  assign cs_fall  = ~cs_ni & cs_q;
  assign sh_nxt   = {sh_q[30:0], mosi_i};
  assign rd_act   = ~cs_ni & opc_vld_q & (opcode_q == OP_RDSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
    end
  end

  // input shifter and field capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      bits_q    <= '0;
      opc_vld_q <= 1'b0;
      opcode_q  <= '0;
      data_q    <= '0;
      addr_q    <= '0;
    end else if (soft_rst_i || cs_fall) begin
      sh_q      <= '0;
      bits_q    <= '0;
      opc_vld_q <= 1'b0;
    end else if (sck_rise && !cs_ni) begin
      sh_q <= sh_nxt;
      if (bits_q != '1) bits_q <= bits_q + 1'b1;
      if (bits_q == CNT_W'(7)) begin
        opcode_q  <= sh_nxt[7:0];
        opc_vld_q <= 1'b1;
      end
      if (bits_q == CNT_W'(15)) data_q <= sh_nxt[7:0];
      if (bits_q == CNT_W'(31)) addr_q <= sh_nxt[WIRE_ADDR_W-1:0];
    end
  end

  // status byte streamer: reload at each byte boundary with live value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (soft_rst_i || cs_ni) begin
      oe_q <= 1'b0;
    end else if (sck_fall && rd_act) begin
      oe_q <= 1'b1;
      if (bits_q[2:0] == 3'd0) begin
        miso_q <= status_i[7];
        out_q  <= {status_i[6:0], 1'b0};
      end else begin
        miso_q <= out_q[7];
        out_q  <= {out_q[6:0], 1'b0};
      end
    end
  end

  assign miso_o      = miso_q;
  assign miso_oe_o   = oe_q;
  assign frame_end_o = cs_ni & ~cs_q & ~soft_rst_i;
  assign opcode_o    = opc_vld_q ? opcode_q : 8'h00;
  assign data_o      = data_q;
  assign addr_o      = addr_q[ADDR_W-1:0];
  assign bits_o      = bits_q;

  // R3
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !miso_oe_o);
  // R3
  oe_opcode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miso_oe_o) |-> (bits_o >= CNT_W'(8)));
endmodule

// File: rtl/sfsr_prot.sv
module sfsr_prot #(
  parameter int ADDR_W = 24
) (
  input  logic [2:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  int   span;
  logic top_ones;

  // region = top 1/2^(8-bp): top (8-bp) address bits all ones
  always_comb begin
    span     = 8 - int'(bp_i);
    top_ones = 1'b1;
    for (int j = 0; j < ADDR_W; j++) begin
      if (j >= ADDR_W - span) top_ones = top_ones & addr_i[j];
    end
    hit_o = (bp_i == 3'd7) || ((bp_i != 3'd0) && top_ones);
  end
endmodule

// File: rtl/sfsr_status.sv
module sfsr_status
  import sfsr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wp_ni,
  input  logic              frame_end_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  bits_i,
  input  logic              prot_hit_i,
  output logic [7:0]        status_o,
  output logic [2:0]        bp_o,
  output logic              op_go_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic srwd_q, wel_q, wip_q;
  logic [2:0] bp_q;
  logic [BW-1:0] busy_q;
  logic go_q;
  op_kind_e kind_q;
  logic [ADDR_W-1:0] go_addr_q;

  logic idle_end, hw_lock, wren_ok, wrsr_ok, pp_ok, se_ok, be_ok, start;
  op_kind_e kind_d;

  assign idle_end = frame_end_i & ~wip_q;
  assign hw_lock  = srwd_q & ~wp_ni;
  assign wren_ok  = idle_end && opcode_i == OP_WREN && bits_i == CNT_W'(8);
  assign wrsr_ok  = idle_end && wel_q && opcode_i == OP_WRSR &&
                    bits_i == CNT_W'(16) && !hw_lock;
  assign pp_ok    = idle_end && wel_q && opcode_i == OP_PP &&
                    bits_i >= CNT_W'(40) && bits_i[2:0] == 3'd0 && !prot_hit_i;
  assign se_ok    = idle_end && wel_q && opcode_i == OP_SE &&
                    bits_i == CNT_W'(32) && !prot_hit_i;
  assign be_ok    = idle_end && wel_q && opcode_i == OP_BE &&
                    bits_i == CNT_W'(8) && bp_q == 3'd0;
  assign start    = wrsr_ok | pp_ok | se_ok | be_ok;

  always_comb begin
    kind_d = KIND_NONE;
    if (pp_ok)      kind_d = KIND_PP;
    else if (se_ok) kind_d = KIND_SE;
    else if (be_ok) kind_d = KIND_BE;
  end

  // non-volatile bits: cleared only by rst_ni
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srwd_q <= 1'b0;
      bp_q   <= '0;
    end else if (wrsr_ok && !soft_rst_i) begin
      srwd_q <= data_i[7];
      bp_q   <= data_i[4:2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q     <= 1'b0;
      wip_q     <= 1'b0;
      busy_q    <= '0;
      go_q      <= 1'b0;
      kind_q    <= KIND_NONE;
      go_addr_q <= '0;
    end else if (soft_rst_i) begin
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
      busy_q <= '0;
      go_q   <= 1'b0;
    end else begin
      go_q <= pp_ok | se_ok | be_ok;
      if (pp_ok | se_ok | be_ok) begin
        kind_q    <= kind_d;
        go_addr_q <= be_ok ? '0 : addr_i;
      end
      if (wren_ok) wel_q <= 1'b1;
      if (start) begin
        wip_q  <= 1'b1;
        busy_q <= BW'(BUSY_CYCLES);
      end else if (wip_q) begin
        busy_q <= busy_q - 1'b1;
        if (busy_q == BW'(1)) begin
          wip_q <= 1'b0;
          wel_q <= 1'b0;
        end
      end
    end
  end

  assign status_o  = {srwd_q, 2'b00, bp_q, wel_q, wip_q};
  assign bp_o      = bp_q;
  assign op_go_o   = go_q;
  assign op_kind_o = kind_q;
  assign op_addr_o = go_addr_q;

  // R6
  wip_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_q) |-> !wel_q);
  // R6
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip_q && $past(wip_q)) |-> !op_go_o);
  // R7
  go_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_go_o |-> $past(wel_q));
  // R9
  be_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_go_o && op_kind_o == KIND_BE) |-> (bp_q == 3'd0));
  // R10
  hw_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srwd_q && !wp_ni) |=> $stable({srwd_q, bp_q}));
endmodule

// File: rtl/sfsr_unit.sv
module sfsr_unit
  import sfsr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 16,
  parameter int BUSY_CYCLES = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic              wp_ni,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              op_go_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o
);
  logic [7:0] status, opcode, data;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0] bits;
  logic [2:0] bp;
  logic frame_end, prot_hit;

  sfsr_spi_front #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) front_i (
    .clk_i, .rst_ni, .soft_rst_i, .sck_i, .cs_ni, .mosi_i,
    .status_i(status), .miso_o, .miso_oe_o,
    .frame_end_o(frame_end), .opcode_o(opcode), .data_o(data),
    .addr_o(addr), .bits_o(bits)
  );

  sfsr_prot #(.ADDR_W(ADDR_W)) prot_i (
    .bp_i(bp), .addr_i(addr), .hit_o(prot_hit)
  );

  sfsr_status #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUSY_CYCLES(BUSY_CYCLES)) status_i (
    .clk_i, .rst_ni, .soft_rst_i, .wp_ni,
    .frame_end_i(frame_end), .opcode_i(opcode), .data_i(data),
    .addr_i(addr), .bits_i(bits), .prot_hit_i(prot_hit),
    .status_o(status), .bp_o(bp),
    .op_go_o, .op_kind_o, .op_addr_o
  );

  // R1
  status_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[6:5] == 2'b00);
endmodule

// File: tb/sfsr_unit_tb_top.sv
module sfsr_unit_tb_top;
  localparam int BUSY = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe, op_go;
  logic [1:0] op_kind;
  logic [23:0] op_addr;

  int n_cmp = 0, n_bad = 0;
  int go_cnt = 0;
  logic [1:0] last_kind;
  logic [23:0] last_addr;

  always #10 clk = ~clk;

  sfsr_unit #(.ADDR_W(24), .CNT_W(16), .BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .wp_ni(wp_n),
    .miso_o(miso), .miso_oe_o(miso_oe),
    .op_go_o(op_go), .op_kind_o(op_kind), .op_addr_o(op_addr)
  );

  always @(posedge clk) if (op_go) begin
    go_cnt    <= go_cnt + 1;
    last_kind <= op_kind;
    last_addr <= op_addr;
  end

  // {bp[2:0], kind[1:0], accept, addr[23:0]}; kind 1=PP 2=SE 3=BE
  localparam logic [29:0] VEC [11] = '{
    {3'd0, 2'd1, 1'b1, 24'hFFFFFF},
    {3'd1, 2'd1, 1'b0, 24'hFFFFFF},
    {3'd1, 2'd2, 1'b1, 24'hFDFFFF},
    {3'd1, 2'd2, 1'b0, 24'hFE0000},
    {3'd6, 2'd1, 1'b1, 24'hBFFFFF},
    {3'd6, 2'd1, 1'b0, 24'hC00000},
    {3'd3, 2'd2, 1'b1, 24'hF7FFFF},
    {3'd3, 2'd2, 1'b0, 24'hF80000},
    {3'd7, 2'd2, 1'b0, 24'h000000},
    {3'd0, 2'd3, 1'b1, 24'h000000},
    {3'd2, 2'd3, 1'b0, 24'h000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic xfer(input logic [47:0] tx, input int nbits,
                      output logic [31:0] rx, output int oe_bad);
    rx = '0;
    oe_bad = 0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[47-i];
      repeat (4) @(negedge clk);
      if (i < 8 && miso_oe) oe_bad++;
      if (i >= 8) begin
        rx = {rx[30:0], miso};
        if (!miso_oe) oe_bad++;
      end
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send(input logic [47:0] tx, input int nbits);
    logic [31:0] rx;
    int b;
    xfer(tx, nbits, rx, b);
  endtask

  task automatic read_sr(output logic [7:0] s);
    logic [31:0] rx;
    int b;
    xfer({8'h05, 40'h0}, 16, rx, b);
    s = rx[7:0];
  endtask

  task automatic wren();
    send({8'h06, 40'h0}, 8);
  endtask

  task automatic wrsr(input logic [7:0] d);
    send({8'h01, d, 32'h0}, 16);
  endtask

  task automatic wait_busy();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [31:0] rx;
    int oe_bad, g0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, R3 enable low during opcode
    xfer({8'h05, 40'h0}, 16, rx, oe_bad);
    chk("R1 reset status", {24'h0, rx[7:0]}, 32'h00);
    chk("R3 oe during opcode/read", oe_bad, 0);
    chk("R3 oe after cs high", {31'h0, miso_oe}, 0);

    // R7 no WEL: status write and bulk erase ignored
    g0 = go_cnt;
    wrsr(8'h9C);
    send({8'hC7, 40'h0}, 8);
    read_sr(s);
    chk("R7 wrsr without wel", {24'h0, s}, 32'h00);
    chk("R7 be without wel", go_cnt - g0, 0);

    // R4 short frame ignored, full frame sets WEL
    send({8'h06, 40'h0}, 7);
    read_sr(s);
    chk("R4 7-bit wren", {24'h0, s}, 32'h00);
    wren();
    read_sr(s);
    chk("R4 wren sets wel", {24'h0, s}, 32'h02);

    // R5 write, R2 continuous stream with live value, R6 busy end
    wrsr(8'h9C);
    xfer({8'h05, 40'h0}, 40, rx, oe_bad);
    chk("R5 R6 first byte busy", {24'h0, rx[31:24]}, 32'h9F);
    chk("R2 R6 last byte live", {24'h0, rx[7:0]}, 32'h9C);
    chk("R2 oe held while streaming", oe_bad, 0);

    // R10 hardware protection
    wp_n = 1'b0;
    wren();
    wrsr(8'h00);
    read_sr(s);
    chk("R10 locked write rejected", {24'h0, s}, 32'h9E);
    wp_n = 1'b1;
    wrsr(8'h00);
    wait_busy();
    read_sr(s);
    chk("R10 unlocked write ok", {24'h0, s}, 32'h00);

    // R6 commands ignored while busy
    wren();
    wrsr(8'h00);
    g0 = go_cnt;
    wren();
    send({8'hC7, 40'h0}, 8);
    wait_busy();
    chk("R6 be ignored while busy", go_cnt - g0, 0);
    read_sr(s);
    chk("R6 wel cleared at end", {24'h0, s}, 32'h00);

    // R8 R9 R11 protection decode table
    for (int v = 0; v < 11; v++) begin
      logic [2:0] bp;
      logic [1:0] kind;
      logic acc;
      logic [23:0] a;
      {bp, kind, acc, a} = VEC[v];
      wren();
      wrsr({3'b000, bp, 2'b00});
      wait_busy();
      wren();
      g0 = go_cnt;
      case (kind)
        2'd1: send({8'h02, a, 8'hA5, 8'h0}, 40);
        2'd2: send({8'hD8, a, 16'h0}, 32);
        default: send({8'hC7, 40'h0}, 8);
      endcase
      repeat (4) @(negedge clk);
      chk(kind == 2'd3 ? "R9 bulk erase gate" : "R8 region gate", go_cnt - g0, {31'h0, acc});
      if (acc) begin
        chk("R11 op kind", {30'h0, last_kind}, {30'h0, kind});
        chk("R11 op addr", {8'h0, last_addr}, {8'h0, a});
        wait_busy();
      end
    end

    // R12 soft reset keeps BP/SRWD, hard reset clears all
    wren();
    wrsr(8'h88);
    wait_busy();
    wren();
    read_sr(s);
    chk("R12 before soft reset", {24'h0, s}, 32'h8A);
    @(negedge clk);
    soft_rst = 1'b1;
    repeat (2) @(negedge clk);
    soft_rst = 1'b0;
    read_sr(s);
    chk("R12 soft reset keeps nv", {24'h0, s}, 32'h88);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    read_sr(s);
    chk("R12 hard reset clears", {24'h0, s}, 32'h00);

    report();
    $finish;
  end
endmodule